// File: doc/BRIEF.md
# Two-Sided Processor Mailbox

This block connects two processors, called side A and side B, that share one clock. Each side sees a small register bank of its own through a simple synchronous read/write port. The bank has a sync register, a control/status register and a 32-bit data port. Through the sync register a side shows a 4-bit value to the other side and can ring a doorbell interrupt on the other side. Through the data port a side pushes words into a FIFO that only the other side pops.

Each direction has its own 16-word FIFO, so a side's send FIFO is the other side's receive FIFO. The control register reports empty and full for both FIFOs. It enables level interrupts for "send FIFO empty" and "receive FIFO not empty", flushes the send FIFO, and gates all data movement with a per-side enable. A sticky error flag records a push into a full FIFO or a pop from an empty one. Software frames messages on top of this block.

Register offsets on `x_addr`: 0 is the sync register, 1 is the control register, 2 is the data port, and 3 reads as zero. A write takes effect at the clock edge where `x_wr_en` is high. Read data appears on `x_rdata` in the cycle after the one in which `x_rd_en` is high. The status fields in that read data are sampled in the cycle of the request.

Top module: `duo_mailbox`

## Requirements
- R1: After reset every interrupt output is low, the sync register reads 0x0000_0000 and the control register reads 0x0000_0101 (bit 0 = send empty, bit 8 = receive empty).
- R2: The nibble written into sync bits 11:8 on one side reads back in bits 11:8 on that side and appears in sync bits 3:0 of the other side.
- R3: Writing sync bit 13 = 1 on one side sets the other side's doorbell pending flag (sync bit 15, `x_irq_bell`), but only if that side's sync bit 14 is 1 at that moment. Writing bit 13 = 0 does nothing, and a doorbell rung while bit 14 is 0 is lost.
- R4: Writing sync bit 15 = 1 clears this side's doorbell pending flag and drops `x_irq_bell`.
- R5: Words written to the data port on one side are read from the other side's data port in the same order, up to 16 words.
- R6: Control bits 0 and 1 show send FIFO empty and full, and bits 8 and 9 show receive FIFO empty and full.
- R7: `x_irq_tx_empty` equals control bit 2 AND send-FIFO-empty. `x_irq_rx_ready` equals control bit 10 AND receive-FIFO-not-empty.
- R8: Writing control bit 3 = 1 empties this side's send FIFO in that cycle, so the other side sees its receive FIFO empty.
- R9: With control bit 15 = 1, a data write to a full send FIFO drops the word and a data read of an empty receive FIFO returns the last word read with no FIFO change. Either access sets the sticky control bit 14, and writing 1 to bit 14 clears it.
- R10: While control bit 15 is 0, data-port writes and reads move no data and never set bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_wr_en | input | 1 | Side A register write strobe |
| a_rd_en | input | 1 | Side A register read strobe |
| a_addr | input | 2 | Side A register offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, one cycle after the strobe |
| a_irq_bell | output | 1 | Side A doorbell pending |
| a_irq_tx_empty | output | 1 | Side A send FIFO empty interrupt |
| a_irq_rx_ready | output | 1 | Side A receive FIFO not-empty interrupt |
| b_wr_en | input | 1 | Side B register write strobe |
| b_rd_en | input | 1 | Side B register read strobe |
| b_addr | input | 2 | Side B register offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, one cycle after the strobe |
| b_irq_bell | output | 1 | Side B doorbell pending |
| b_irq_tx_empty | output | 1 | Side B send FIFO empty interrupt |
| b_irq_rx_ready | output | 1 | Side B receive FIFO not-empty interrupt |

## Verification
The assertions assume that the strobes of each side are clean single-cycle register accesses and that the FIFO depth is a power of two. The pointer wrap used in the occupancy checks relies on that depth. They also assume that a flush and a push on the same FIFO never coincide, which holds because both come from the same side's single write port. The bench drives each side's strobes on the falling edge, issues at most one write or read per side per cycle, and sends each control write as a complete register value. This keeps the enable bits in a known state around every flush, error clear and disable step.

// File: rtl/mbx_pkg.sv
// Package: shared register offsets and bit positions of the mailbox bank.
// Assumes a 2-bit offset field on each side's register port.
package mbx_pkg;
    typedef enum logic [1:0] {
        MBX_SYNC = 2'd0,
        MBX_CTRL = 2'd1,
        MBX_DATA = 2'd2,
        MBX_RSVD = 2'd3
    } mbx_reg_e;

    // sync register fields
    localparam int SY_IN_LSB   = 0;
    localparam int SY_OUT_LSB  = 8;
    localparam int SY_RING     = 13;
    localparam int SY_BELL_EN  = 14;
    localparam int SY_PEND     = 15;
    localparam int NIB_W       = 4;

    // control register fields
    localparam int CT_TX_EMPTY = 0;
    localparam int CT_TX_FULL  = 1;
    localparam int CT_TXE_IE   = 2;
    localparam int CT_FLUSH    = 3;
    localparam int CT_RX_EMPTY = 8;
    localparam int CT_RX_FULL  = 9;
    localparam int CT_RXNE_IE  = 10;
    localparam int CT_ERR      = 14;
    localparam int CT_ENABLE   = 15;
endpackage

// File: rtl/mbx_fifo.sv
// Module: mbx_fifo
// Word FIFO for one mailbox direction. It has occupancy-count status and a
// synchronous flush. It assumes DEPTH is a power of two. A push while full
// and a pop while empty are ignored here. Flush has priority over push and pop.
module mbx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // Storage array write.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> (count == $past(count) + 1'b1)); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R8
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty); // R9
endmodule

// File: rtl/mbx_port.sv
// Module: mbx_port
// Register bank of one mailbox side. It decodes register accesses, keeps the
// sync, doorbell, enable and error state, and turns data-port accesses into
// FIFO push and pop strobes. It assumes one access per strobe and the shared
// clock. Read data is registered and follows the strobe by one cycle.
module mbx_port
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    // remote side links
    input  logic [NIB_W-1:0]  nib_in,
    output logic [NIB_W-1:0]  nib_out,
    input  logic              bell_in,
    output logic              bell_out,
    // FIFO links
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic [DATA_W-1:0] rx_head,
    output logic              tx_push,
    output logic              tx_flush,
    output logic              rx_pop,
    // interrupts
    output logic              irq_bell,
    output logic              irq_tx_empty,
    output logic              irq_rx_ready
);
    mbx_reg_e          reg_sel;
    logic              wr_sync, wr_ctrl, wr_data, rd_data, bad_acc;
    logic              bell_en, bell_pend, txe_ie, rxne_ie, err, fifo_en;
    logic [DATA_W-1:0] last_word, sync_view, ctrl_view;
    logic              unused_wbits;

    assign reg_sel = mbx_reg_e'(addr);
    assign wr_sync = wr_en && (reg_sel == MBX_SYNC);
    assign wr_ctrl = wr_en && (reg_sel == MBX_CTRL);
    assign wr_data = wr_en && (reg_sel == MBX_DATA);
    assign rd_data = rd_en && (reg_sel == MBX_DATA);

    assign tx_push  = wr_data && fifo_en && !tx_full;
    assign rx_pop   = rd_data && fifo_en && !rx_empty;
    assign bad_acc  = fifo_en && ((wr_data && tx_full) || (rd_data && rx_empty));
    assign tx_flush = wr_ctrl && wdata[CT_FLUSH];
    assign bell_out = wr_sync && wdata[SY_RING];

    assign irq_bell     = bell_pend;
    assign irq_tx_empty = txe_ie && tx_empty;
    assign irq_rx_ready = rxne_ie && !rx_empty;

    assign unused_wbits = ^{wdata[DATA_W-1:16], wdata[13:11], wdata[9:4], wdata[1:0]};

    // Readable images of the sync and control registers.
    always_comb begin
        sync_view = '0;
        sync_view[SY_IN_LSB +: NIB_W]  = nib_in;
        sync_view[SY_OUT_LSB +: NIB_W] = nib_out;
        sync_view[SY_BELL_EN]          = bell_en;
        sync_view[SY_PEND]             = bell_pend;
        ctrl_view = '0;
        ctrl_view[CT_TX_EMPTY] = tx_empty;
        ctrl_view[CT_TX_FULL]  = tx_full;
        ctrl_view[CT_TXE_IE]   = txe_ie;
        ctrl_view[CT_RX_EMPTY] = rx_empty;
        ctrl_view[CT_RX_FULL]  = rx_full;
        ctrl_view[CT_RXNE_IE]  = rxne_ie;
        ctrl_view[CT_ERR]      = err;
        ctrl_view[CT_ENABLE]   = fifo_en;
    end

    // Sync register state: outgoing nibble and doorbell enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_out <= '0;
            bell_en <= 1'b0;
        end else if (wr_sync) begin
            nib_out <= wdata[SY_OUT_LSB +: NIB_W];
            bell_en <= wdata[SY_BELL_EN];
        end
    end

    // Doorbell pending flag: set by an enabled remote ring, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bell_pend <= 1'b0;
        end else if (bell_in && bell_en) begin
            bell_pend <= 1'b1;
        end else if (wr_sync && wdata[SY_PEND]) begin
            bell_pend <= 1'b0;
        end
    end

    // Control register state: enables and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            txe_ie  <= 1'b0;
            rxne_ie <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                fifo_en <= wdata[CT_ENABLE];
                txe_ie  <= wdata[CT_TXE_IE];
                rxne_ie <= wdata[CT_RXNE_IE];
            end
            if (bad_acc) begin
                err <= 1'b1;
            end else if (wr_ctrl && wdata[CT_ERR]) begin
                err <= 1'b0;
            end
        end
    end

    // Registered read data, and the word an empty read replays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            last_word <= '0;
        end else begin
            if (rx_pop) last_word <= rx_head;
            if (rd_en) begin
                case (reg_sel)
                    MBX_SYNC: rdata <= sync_view;
                    MBX_CTRL: rdata <= ctrl_view;
                    MBX_DATA: rdata <= rx_pop ? rx_head : last_word;
                    default:  rdata <= '0;
                endcase
            end
        end
    end

    AST_BELL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_bell) |-> $past(bell_in && bell_en)); // R3
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(fifo_en && wr_en && addr == 2'd2 && tx_full)
                    || $past(fifo_en && rd_en && addr == 2'd2 && rx_empty)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(wr_en && addr == 2'd1 && wdata[CT_ERR])) |=> err); // R9
    AST_DISABLED_NOMOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !(tx_push || rx_pop)); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && wdata[SY_PEND] && !bell_in) |=> !irq_bell); // R4
endmodule

// File: rtl/duo_mailbox.sv
// Module: duo_mailbox
// Top of the two-sided mailbox. It holds one register bank per side and one
// FIFO per direction. The sync nibbles and doorbells are cross-wired between
// the sides. It assumes both sides run on the one shared clock.
module duo_mailbox #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr_en,
    input  logic              a_rd_en,
    input  logic [1:0]        a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_bell,
    output logic              a_irq_tx_empty,
    output logic              a_irq_rx_ready,
    input  logic              b_wr_en,
    input  logic              b_rd_en,
    input  logic [1:0]        b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_bell,
    output logic              b_irq_tx_empty,
    output logic              b_irq_rx_ready
);
    import mbx_pkg::*;

    logic [NIB_W-1:0]  a_nib, b_nib;
    logic              a_ring, b_ring;
    logic              ab_push, ab_pop, ab_flush, ab_empty, ab_full;
    logic              ba_push, ba_pop, ba_flush, ba_empty, ba_full;
    logic [DATA_W-1:0] ab_head, ba_head;

    // A to B direction.
    mbx_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo_ab (
        .clk(clk), .rst_n(rst_n), .push(ab_push), .pop(ab_pop), .flush(ab_flush),
        .din(a_wdata), .head(ab_head), .empty(ab_empty), .full(ab_full)
    );

    // B to A direction.
    mbx_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo_ba (
        .clk(clk), .rst_n(rst_n), .push(ba_push), .pop(ba_pop), .flush(ba_flush),
        .din(b_wdata), .head(ba_head), .empty(ba_empty), .full(ba_full)
    );

    mbx_port #(.DATA_W(DATA_W)) u_side_a (
        .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .rd_en(a_rd_en), .addr(a_addr),
        .wdata(a_wdata), .rdata(a_rdata), .nib_in(b_nib), .nib_out(a_nib),
        .bell_in(b_ring), .bell_out(a_ring),
        .tx_empty(ab_empty), .tx_full(ab_full), .rx_empty(ba_empty), .rx_full(ba_full),
        .rx_head(ba_head), .tx_push(ab_push), .tx_flush(ab_flush), .rx_pop(ba_pop),
        .irq_bell(a_irq_bell), .irq_tx_empty(a_irq_tx_empty), .irq_rx_ready(a_irq_rx_ready)
    );

    mbx_port #(.DATA_W(DATA_W)) u_side_b (
        .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .rd_en(b_rd_en), .addr(b_addr),
        .wdata(b_wdata), .rdata(b_rdata), .nib_in(a_nib), .nib_out(b_nib),
        .bell_in(a_ring), .bell_out(b_ring),
        .tx_empty(ba_empty), .tx_full(ba_full), .rx_empty(ab_empty), .rx_full(ab_full),
        .rx_head(ab_head), .tx_push(ba_push), .tx_flush(ba_flush), .rx_pop(ab_pop),
        .irq_bell(b_irq_bell), .irq_tx_empty(b_irq_tx_empty), .irq_rx_ready(b_irq_rx_ready)
    );

    AST_NIB_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_addr == 2'd0) |=> (a_nib == $past(a_wdata[SY_OUT_LSB +: NIB_W]))); // R2
endmodule

// File: tb/duo_mailbox_tb.sv
// Directed bench for duo_mailbox: one task per scenario, each checking its results.
module duo_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr_en = 1'b0, a_rd_en = 1'b0, b_wr_en = 1'b0, b_rd_en = 1'b0;
    logic [1:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq_bell, a_irq_tx_empty, a_irq_rx_ready;
    logic        b_irq_bell, b_irq_tx_empty, b_irq_rx_ready;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [1:0] SYNC = 2'd0, CTRL = 2'd1, DATA = 2'd2;
    localparam bit SA = 1'b0, SB = 1'b1;

    always #2.5 clk = ~clk; // 200 MHz

    duo_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq_bell(a_irq_bell), .a_irq_tx_empty(a_irq_tx_empty),
        .a_irq_rx_ready(a_irq_rx_ready),
        .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq_bell(b_irq_bell), .b_irq_tx_empty(b_irq_tx_empty),
        .b_irq_rx_ready(b_irq_rx_ready)
    );

    task automatic check(input string req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(input bit side, input logic [1:0] adr, input logic [31:0] d);
        if (side == SA) begin a_wr_en = 1'b1; a_addr = adr; a_wdata = d; end
        else            begin b_wr_en = 1'b1; b_addr = adr; b_wdata = d; end
        @(negedge clk);
        a_wr_en = 1'b0;
        b_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input bit side, input logic [1:0] adr, output logic [31:0] d);
        if (side == SA) begin a_rd_en = 1'b1; a_addr = adr; end
        else            begin b_rd_en = 1'b1; b_addr = adr; end
        @(negedge clk);
        d = (side == SA) ? a_rdata : b_rdata;
        a_rd_en = 1'b0;
        b_rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_rd(SA, CTRL, v); check("R1", "A ctrl after reset", v, 32'h0000_0101);
        bus_rd(SB, SYNC, v); check("R1", "B sync after reset", v, 32'h0);
        check("R1", "irq lines after reset",
              {26'b0, a_irq_bell, a_irq_tx_empty, a_irq_rx_ready,
               b_irq_bell, b_irq_tx_empty, b_irq_rx_ready}, 32'h0);
    endtask

    task automatic t_nibble();
        logic [31:0] v;
        bus_wr(SA, SYNC, 32'h0000_0A00);
        bus_rd(SB, SYNC, v); check("R2", "B sees A nibble", v, 32'h0000_000A);
        bus_rd(SA, SYNC, v); check("R2", "A nibble readback", v, 32'h0000_0A00);
        bus_wr(SB, SYNC, 32'h0000_0500);
        bus_rd(SA, SYNC, v); check("R2", "A sees B nibble", v, 32'h0000_0A05);
    endtask

    task automatic t_bell();
        logic [31:0] v;
        bus_wr(SB, SYNC, 32'h0000_4500);           // B enables doorbell
        bus_wr(SA, SYNC, 32'h0000_2A00);           // A rings
        check("R3", "B bell irq after ring", {31'b0, b_irq_bell}, 32'h1);
        check("R3", "A bell irq stays low", {31'b0, a_irq_bell}, 32'h0);
        bus_rd(SB, SYNC, v); check("R3", "B sync with pending", v, 32'h0000_C50A);
        bus_wr(SB, SYNC, 32'h0000_C500);           // ack
        check("R4", "B bell irq after ack", {31'b0, b_irq_bell}, 32'h0);
        bus_wr(SA, SYNC, 32'h0000_0A00);           // bit13 = 0
        check("R3", "no ring on bit13=0", {31'b0, b_irq_bell}, 32'h0);
        bus_wr(SB, SYNC, 32'h0000_0500);           // disable
        bus_wr(SA, SYNC, 32'h0000_2A00);
        bus_wr(SB, SYNC, 32'h0000_4500);           // re-enable: ring was lost
        check("R3", "ring while disabled lost", {31'b0, b_irq_bell}, 32'h0);
    endtask

    task automatic t_fifo();
        logic [31:0] v;
        bus_wr(SA, CTRL, 32'h0000_8000);
        bus_wr(SB, CTRL, 32'h0000_8000);
        for (int i = 0; i < 3; i++) bus_wr(SA, DATA, 32'h1111_0000 + i);
        bus_rd(SB, CTRL, v); check("R6", "B ctrl rx not empty", v, 32'h0000_8001);
        bus_rd(SA, CTRL, v); check("R6", "A ctrl tx not empty", v, 32'h0000_8100);
        for (int i = 0; i < 3; i++) begin
            bus_rd(SB, DATA, v); check("R5", "short burst order", v, 32'h1111_0000 + i);
        end
        for (int i = 0; i < 16; i++) bus_wr(SA, DATA, 32'hC0DE_0000 + i);
        bus_rd(SA, CTRL, v); check("R6", "A ctrl tx full", v, 32'h0000_8102);
        bus_rd(SB, CTRL, v); check("R6", "B ctrl rx full", v, 32'h0000_8201);
        bus_wr(SA, DATA, 32'hDEAD_BEEF);           // overflow
        bus_rd(SA, CTRL, v); check("R9", "A error after full write", v, 32'h0000_C102);
        for (int i = 0; i < 16; i++) begin
            bus_rd(SB, DATA, v); check("R5", "full burst order", v, 32'hC0DE_0000 + i);
        end
        bus_rd(SB, CTRL, v); check("R9", "dropped word absent", v, 32'h0000_8101);
        bus_rd(SB, DATA, v); check("R9", "empty read replays last", v, 32'hC0DE_000F);
        bus_rd(SB, CTRL, v); check("R9", "B error after empty read", v, 32'h0000_C101);
        bus_wr(SB, CTRL, 32'h0000_C000);
        bus_rd(SB, CTRL, v); check("R9", "B error cleared", v, 32'h0000_8101);
        bus_wr(SA, CTRL, 32'h0000_C000);
        bus_rd(SA, CTRL, v); check("R9", "A error cleared", v, 32'h0000_8101);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        bus_wr(SA, CTRL, 32'h0000_8004);
        check("R7", "tx empty irq on", {31'b0, a_irq_tx_empty}, 32'h1);
        bus_wr(SA, DATA, 32'hFEED_0001);
        check("R7", "tx empty irq off", {31'b0, a_irq_tx_empty}, 32'h0);
        check("R7", "rx irq masked", {31'b0, b_irq_rx_ready}, 32'h0);
        bus_wr(SB, CTRL, 32'h0000_8400);
        check("R7", "rx ready irq on", {31'b0, b_irq_rx_ready}, 32'h1);
        bus_rd(SB, DATA, v); check("R5", "irq word", v, 32'hFEED_0001);
        check("R7", "rx ready irq off", {31'b0, b_irq_rx_ready}, 32'h0);
        check("R7", "tx empty irq back", {31'b0, a_irq_tx_empty}, 32'h1);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        bus_wr(SA, DATA, 32'hAAAA_0001);
        bus_wr(SA, DATA, 32'hAAAA_0002);
        bus_wr(SA, CTRL, 32'h0000_8008);
        bus_rd(SA, CTRL, v); check("R8", "A tx empty after flush", v, 32'h0000_8101);
        bus_rd(SB, CTRL, v); check("R8", "B rx empty after flush", v, 32'h0000_8501);
        check("R8", "rx irq after flush", {31'b0, b_irq_rx_ready}, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        bus_wr(SA, CTRL, 32'h0000_0000);
        bus_wr(SA, DATA, 32'h0000_1234);
        bus_rd(SB, CTRL, v); check("R10", "no push while disabled", v, 32'h0000_8501);
        bus_rd(SA, CTRL, v); check("R10", "no error while disabled", v, 32'h0000_0101);
        bus_wr(SB, CTRL, 32'h0000_0000);
        bus_wr(SA, CTRL, 32'h0000_8000);
        bus_wr(SA, DATA, 32'h5555_AAAA);
        bus_rd(SB, DATA, v); check("R10", "disabled read replays", v, 32'hFEED_0001);
        bus_rd(SB, CTRL, v); check("R10", "no pop while disabled", v, 32'h0000_0001);
        bus_wr(SB, CTRL, 32'h0000_8000);
        bus_rd(SB, DATA, v); check("R10", "word kept for later", v, 32'h5555_AAAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nibble();
        t_bell();
        t_fifo();
        t_irq();
        t_flush();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule